// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a small non-pipelined processor for a register machine with a load/store instruction set. Each instruction walks through up to five clock steps: instruction fetch, decode with register read, execute or address calculation, memory access or branch resolution, and register write-back. Classes that need fewer steps leave early. Values move from one step to the next through internal holding registers that software cannot see.

The core drives a single word-wide memory port that serves both instruction fetches and data transfers. Read data must be valid in the same cycle as the address. A separate flag marks the fetch cycles. Instructions are 32 bits wide. The opcode sits in bits [31:26], the first source register in [25:21] and the second source register (or the load/store data register) in [20:16]. Register operations put the destination in [15:11] and the function code in [5:0]. Other classes carry a 16-bit signed immediate in [15:0].

The reset input is asynchronous and active low. Its release is synchronised inside the core. One idle step then passes before the first fetch.

Top module: `stepwise_core`

## Requirements
- R1: While rst_n is low, mem_rd, mem_wr and mem_ifetch stay low. After release, the first instruction fetch reads address RESET_PC (0 by default).
- R2: Step counts, from one fetch to the next: register operation or compare 4 cycles, load (opcode 1) 5, store (opcode 2) 4, branch (opcodes 3 and 4) 4. No instruction ever exceeds 5. The fetch cycle lasts exactly one cycle.
- R3: Opcode 0 is a register operation that writes rd from rs and rt. The function codes are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 shift left logical, 6 shift right logical and 7 shift right arithmetic. Each shift moves rs by rt[4:0].
- R4: Under opcode 0, function codes 8 (equal), 9 (not equal), 10 (signed less than) and 11 (signed greater or equal) write 1 to rd when the condition holds and 0 otherwise.
- R5: Register 0 always reads as zero. Register operations and loads that target it leave it unchanged.
- R6: A load (opcode 1) writes register rt with the memory word at rs plus the sign-extended immediate.
- R7: A store (opcode 2) writes register rt to rs plus the sign-extended immediate. It does so with a single-cycle mem_wr pulse in its fourth step, and the next cycle is a fetch.
- R8: Opcode 3 branches when rs is zero and opcode 4 when rs is non-zero. The target is the branch address plus 4 plus the sign-extended immediate, which may be negative. When the branch is not taken, execution continues at the branch address plus 4.
- R9: mem_rd and mem_wr are never high together. Every fetch cycle has mem_rd high and a word-aligned address.
- R10: Opcodes 5 to 63 retire after fetch and decode (2 cycles) and change no register and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | XLEN | Byte address for fetch or data access |
| mem_rd | output | 1 | Read strobe (fetch or load) |
| mem_wr | output | 1 | Write strobe for a store |
| mem_ifetch | output | 1 | Marks the current read as an instruction fetch |
| mem_wdata | output | XLEN | Store data |
| mem_rdata | input | XLEN | Read data, valid in the same cycle as mem_addr |

## Verification
The bench uses the default parameters: XLEN of 32, 32 registers and RESET_PC of 0. With these values every 5-bit register field maps to a real register, so register 0 and register 31 can both be tested. The word-sized increment of 4 also matches the byte-offset branch immediates. A reference model in the bench predicts the result of every store and the address and step count of every fetch. Branches are taken forward, not taken, and taken backward, so the fetch addresses confirm both the target arithmetic and the fall-through path.

// File: rtl/stepwise_pkg.sv
package stepwise_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_DECODE = 3'd2,
    ST_EXEC   = 3'd3,
    ST_MEM    = 3'd4,
    ST_WBACK  = 3'd5
  } step_e;

  // opcode field [31:26]
  localparam logic [5:0] OP_ALU   = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd1;
  localparam logic [5:0] OP_STORE = 6'd2;
  localparam logic [5:0] OP_BRZ   = 6'd3;
  localparam logic [5:0] OP_BRNZ  = 6'd4;

  // function field [5:0] of register operations
  localparam logic [5:0] FN_ADD = 6'd0;
  localparam logic [5:0] FN_SUB = 6'd1;
  localparam logic [5:0] FN_AND = 6'd2;
  localparam logic [5:0] FN_OR  = 6'd3;
  localparam logic [5:0] FN_XOR = 6'd4;
  localparam logic [5:0] FN_SLL = 6'd5;
  localparam logic [5:0] FN_SRL = 6'd6;
  localparam logic [5:0] FN_SRA = 6'd7;
  localparam logic [5:0] FN_SEQ = 6'd8;
  localparam logic [5:0] FN_SNE = 6'd9;
  localparam logic [5:0] FN_SLT = 6'd10;
  localparam logic [5:0] FN_SGE = 6'd11;

endpackage

// File: rtl/stepwise_alu.sv
module stepwise_alu
  import stepwise_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [5:0]   fn,
  output logic [W-1:0] y
);

  localparam int SHW = $clog2(W);

  logic [SHW-1:0] shamt;
  logic           flag;
  logic           is_cmp;

  assign shamt = b[SHW-1:0];

  // compare results (R4), all signed
  always_comb begin
    flag   = 1'b0;
    is_cmp = 1'b1;
    unique case (fn)
      FN_SEQ:  flag = (a == b);
      FN_SNE:  flag = (a != b);
      FN_SLT:  flag = ($signed(a) <  $signed(b));
      FN_SGE:  flag = ($signed(a) >= $signed(b));
      default: is_cmp = 1'b0;
    endcase
  end

  // arithmetic, logic and shifts (R3)
  always_comb begin
    y = '0;
    unique case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      FN_SLL:  y = a << shamt;
      FN_SRL:  y = a >> shamt;
      FN_SRA:  y = W'($signed(a) >>> shamt);
      default: y = is_cmp ? {{(W-1){1'b0}}, flag} : '0;
    endcase
  end

endmodule

// File: rtl/stepwise_rf.sv
module stepwise_rf #(
  parameter int W     = 32,
  parameter int NREGS = 32,
  localparam int RIDX = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RIDX-1:0] waddr,
  input  logic [W-1:0]    wdata,
  input  logic [RIDX-1:0] raddr_a,
  input  logic [RIDX-1:0] raddr_b,
  output logic [W-1:0]    rdata_a,
  output logic [W-1:0]    rdata_b
);

  logic [NREGS*W-1:0] flat;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      // R5: entry zero is a constant, writes to it go nowhere
      assign flat[0 +: W] = '0;
    end else begin : g_live
      logic [W-1:0] q;
      logic         wen;
      assign wen = we && (waddr == RIDX'(g));
      always_ff @(posedge clk) begin
        if (wen) q <= wdata;
      end
      assign flat[g*W +: W] = q;
    end
  end

  assign rdata_a = flat[W*raddr_a +: W];
  assign rdata_b = flat[W*raddr_b +: W];

endmodule

// File: rtl/stepwise_ctrl.sv
module stepwise_ctrl
  import stepwise_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  output step_e      step
);

  step_e step_q;
  step_e step_d;
  logic  op_known;

  assign op_known = (opcode == OP_ALU)  || (opcode == OP_LOAD) ||
                    (opcode == OP_STORE) || (opcode == OP_BRZ) ||
                    (opcode == OP_BRNZ);

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE:   step_d = ST_FETCH;
      ST_FETCH:  step_d = ST_DECODE;
      ST_DECODE: step_d = op_known ? ST_EXEC : ST_FETCH;           // R10
      ST_EXEC:   step_d = (opcode == OP_ALU) ? ST_WBACK : ST_MEM;  // R2
      ST_MEM:    step_d = (opcode == OP_LOAD) ? ST_WBACK : ST_FETCH;
      ST_WBACK:  step_d = ST_FETCH;
      default:   step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_IDLE;
    else        step_q <= step_d;
  end

  assign step = step_q;

endmodule

// File: rtl/stepwise_core.sv
module stepwise_core
  import stepwise_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              NREGS    = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            mem_ifetch,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata
);

  localparam int RIDX       = $clog2(NREGS);
  localparam int WORD_BYTES = XLEN / 8;

  // reset release synchroniser
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  // step holding registers
  logic [XLEN-1:0] pc_q,  pc_d;
  logic [31:0]     ir_q,  ir_d;
  logic [XLEN-1:0] npc_q, npc_d;
  logic [XLEN-1:0] a_q,   a_d;
  logic [XLEN-1:0] b_q,   b_d;
  logic [XLEN-1:0] res_q, res_d;
  logic [XLEN-1:0] lmd_q, lmd_d;
  logic            take_q, take_d;

  step_e           step;
  logic [5:0]      opcode;
  logic [RIDX-1:0] rs_f, rt_f, rd_f;
  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] pc_inc;
  logic [XLEN-1:0] rf_a, rf_b;
  logic [XLEN-1:0] alu_y;
  logic [XLEN-1:0] exec_y;
  logic            is_alu, is_load, is_store, is_branch;
  logic            rf_we;
  logic [RIDX-1:0] rf_waddr;
  logic [XLEN-1:0] rf_wdata;
  logic            spare_unused;

  assign opcode    = ir_q[31:26];
  assign rs_f      = ir_q[21 +: RIDX];
  assign rt_f      = ir_q[16 +: RIDX];
  assign rd_f      = ir_q[11 +: RIDX];
  assign imm_sx    = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign pc_inc    = pc_q + XLEN'(WORD_BYTES);
  assign spare_unused = ^ir_q[10:6];

  assign is_alu    = (opcode == OP_ALU);
  assign is_load   = (opcode == OP_LOAD);
  assign is_store  = (opcode == OP_STORE);
  assign is_branch = (opcode == OP_BRZ) || (opcode == OP_BRNZ);

  stepwise_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .opcode (opcode),
    .step   (step)
  );

  stepwise_rf #(.W(XLEN), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (rs_f),
    .raddr_b (rt_f),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  stepwise_alu #(.W(XLEN)) u_alu (
    .a  (a_q),
    .b  (b_q),
    .fn (ir_q[5:0]),
    .y  (alu_y)
  );

  // execute-step result: ALU value, branch target or effective address
  always_comb begin
    if (is_alu)         exec_y = alu_y;
    else if (is_branch) exec_y = npc_q + imm_sx;
    else                exec_y = a_q + imm_sx;
  end

  // next values of the holding registers
  always_comb begin
    pc_d   = pc_q;
    ir_d   = ir_q;
    npc_d  = npc_q;
    a_d    = a_q;
    b_d    = b_q;
    res_d  = res_q;
    lmd_d  = lmd_q;
    take_d = take_q;
    unique case (step)
      ST_FETCH: begin
        ir_d  = mem_rdata[31:0];
        npc_d = pc_inc;
        pc_d  = pc_inc;
      end
      ST_DECODE: begin
        a_d = rf_a;
        b_d = rf_b;
      end
      ST_EXEC: begin
        res_d  = exec_y;
        take_d = (a_q == '0) ^ (opcode == OP_BRNZ);
      end
      ST_MEM: begin
        lmd_d = mem_rdata;
        if (is_branch && take_q) pc_d = res_q;   // R8
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q   <= RESET_PC;
      ir_q   <= '0;
      npc_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      res_q  <= '0;
      lmd_q  <= '0;
      take_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      ir_q   <= ir_d;
      npc_q  <= npc_d;
      a_q    <= a_d;
      b_q    <= b_d;
      res_q  <= res_d;
      lmd_q  <= lmd_d;
      take_q <= take_d;
    end
  end

  // write-back
  assign rf_we    = (step == ST_WBACK);
  assign rf_waddr = is_load ? rt_f : rd_f;
  assign rf_wdata = is_load ? lmd_q : res_q;

  // memory port
  assign mem_ifetch = (step == ST_FETCH);
  assign mem_rd     = mem_ifetch || ((step == ST_MEM) && is_load);
  assign mem_wr     = (step == ST_MEM) && is_store;
  assign mem_addr   = mem_ifetch ? pc_q : res_q;
  assign mem_wdata  = b_q;

endmodule

// File: rtl/stepwise_core_chk.sv
module stepwise_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       mem_ifetch,
  input logic [1:0] addr_lo
);

  logic [3:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (mem_ifetch) begin
      gap_q  <= 4'd1;
      seen_q <= 1'b1;
    end else if (gap_q != 4'hF) begin
      gap_q  <= gap_q + 4'd1;
    end
  end

  a_r9_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r9_fetch_reads_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ifetch |-> (mem_rd && addr_lo == 2'b00));

  a_r2_fetch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ifetch |=> !mem_ifetch);

  a_r2_at_most_five: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !mem_ifetch) |-> (gap_q < 4'd5));

  a_r7_store_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> mem_ifetch);

endmodule

bind stepwise_core stepwise_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_ifetch (mem_ifetch),
  .addr_lo    (mem_addr[1:0])
);

// File: tb/test_stepwise_core.sv
module test_stepwise_core;
  import stepwise_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 32;
  localparam int LIMIT      = 20000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [XLEN-1:0] mem_addr;
  logic            mem_rd;
  logic            mem_wr;
  logic            mem_ifetch;
  logic [XLEN-1:0] mem_wdata;
  logic [XLEN-1:0] mem_rdata;

  stepwise_core i_stepwise_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_ifetch (mem_ifetch),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model
  logic [31:0] mem [256];
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input int req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  steps;
    logic [3:0]  req;
  } fetch_t;
  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  req;
  } store_t;
  fetch_t fq[$];
  store_t sq[$];

  // reference model
  logic [31:0] mdl [32];
  logic [31:0] dmod [256];
  logic [31:0] pcb;
  logic [15:0] sptr;

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rd,
                                        input logic [4:0] rs, input logic [4:0] rt);
    return {OP_ALU, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] ref_op(input logic [5:0] fn, input logic [31:0] x,
                                         input logic [31:0] z);
    case (fn)
      FN_ADD: return x + z;
      FN_SUB: return x - z;
      FN_AND: return x & z;
      FN_OR:  return x | z;
      FN_XOR: return x ^ z;
      FN_SLL: return x << z[4:0];
      FN_SRL: return x >> z[4:0];
      FN_SRA: return 32'($signed(x) >>> z[4:0]);
      FN_SEQ: return (x == z) ? 32'd1 : 32'd0;
      FN_SNE: return (x != z) ? 32'd1 : 32'd0;
      FN_SLT: return ($signed(x) <  $signed(z)) ? 32'd1 : 32'd0;
      FN_SGE: return ($signed(x) >= $signed(z)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  // driver: place an instruction and push the expected fetch
  task automatic put(input logic [31:0] w, input int steps, input int req);
    mem[pcb[9:2]] = w;
    fq.push_back({pcb, 4'(steps), 4'(req)});
    pcb = pcb + 32'd4;
  endtask

  task automatic do_alu(input logic [5:0] fn, input logic [4:0] rd, input logic [4:0] rs,
                        input logic [4:0] rt, input int req);
    logic [31:0] v;
    v = ref_op(fn, mdl[rs], mdl[rt]);
    if (rd != 5'd0) mdl[rd] = v;
    put(enc_r(fn, rd, rs, rt), 4, req);
  endtask

  task automatic do_lw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm,
                       input int req);
    logic [31:0] a;
    a = mdl[rs] + sx(imm);
    if (rt != 5'd0) mdl[rt] = dmod[a[9:2]];
    put(enc_i(OP_LOAD, rs, rt, imm), 5, req);
  endtask

  task automatic do_sw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm,
                       input int req);
    logic [31:0] a;
    a = mdl[rs] + sx(imm);
    dmod[a[9:2]] = mdl[rt];
    sq.push_back({a, mdl[rt], 4'(req)});
    put(enc_i(OP_STORE, rs, rt, imm), 4, req);
  endtask

  task automatic st(input logic [4:0] rt, input int req);
    do_sw(rt, 5'd0, sptr, req);
    sptr = sptr + 16'd4;
  endtask

  task automatic alu_st(input logic [5:0] fn, input logic [4:0] rd, input logic [4:0] rs,
                        input logic [4:0] rt, input int req);
    do_alu(fn, rd, rs, rt, req);
    st(rd, req);
  endtask

  // forward branch over nskip words; skipped slots hold a store that must never run
  task automatic do_br(input bit nz, input logic [4:0] rs, input int nskip, input int req);
    bit take;
    take = (mdl[rs] == 32'd0) ^ nz;
    put(enc_i(nz ? OP_BRNZ : OP_BRZ, rs, 5'd0, 16'(4*nskip)), 4, req);
    if (take) begin
      for (int k = 0; k < nskip; k++) begin
        mem[pcb[9:2]] = enc_i(OP_STORE, 5'd0, 5'd1, 16'h03F0);
        pcb = pcb + 32'd4;
      end
    end
  endtask

  // monitor
  bit          have_prev = 1'b0;
  int          last_fetch = 0;
  logic [3:0]  prev_steps = 4'd0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ifetch && fq.size() != 0) begin
        fetch_t e;
        e = fq.pop_front();
        chk(mem_addr == e.addr, int'(e.req), mem_addr, e.addr, "fetch address");
        if (have_prev)   // R2 step count of the previous instruction
          chk((cyc - last_fetch) == int'(prev_steps), 2, 32'(cyc - last_fetch),
              32'(prev_steps), "steps between fetches");
        have_prev  = 1'b1;
        prev_steps = e.steps;
        last_fetch = cyc;
      end
      if (mem_wr) begin
        if (sq.size() == 0) begin
          chk(1'b0, 7, mem_addr, 32'hFFFF_FFFF, "unexpected store");
        end else begin
          store_t s;
          s = sq.pop_front();
          chk(mem_addr == s.addr, int'(s.req), mem_addr, s.addr, "store address");
          chk(mem_wdata == s.data, int'(s.req), mem_wdata, s.data, "store data");
        end
      end
    end
  end

  initial begin
    logic [31:0] halt_pc;
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 32'd0;
      dmod[i] = 32'd0;
    end
    for (int i = 0; i < 32; i++) mdl[i] = 32'd0;
    mem[128] = 32'd5;          dmod[128] = 32'd5;
    mem[129] = 32'hFFFF_FFFD;  dmod[129] = 32'hFFFF_FFFD;
    mem[130] = 32'h0F0F_00FF;  dmod[130] = 32'h0F0F_00FF;
    mem[131] = 32'd4;          dmod[131] = 32'd4;
    mem[132] = 32'h8000_0000;  dmod[132] = 32'h8000_0000;
    pcb  = 32'd0;
    sptr = 16'h0280;

    // R6 loads of the operands (first fetch at 0 checks R1)
    do_lw(5'd1, 5'd0, 16'h0200, 1);
    do_lw(5'd2, 5'd0, 16'h0204, 6);
    do_lw(5'd3, 5'd0, 16'h0208, 6);
    do_lw(5'd4, 5'd0, 16'h020C, 6);
    do_lw(5'd5, 5'd0, 16'h0210, 6);
    // R3 arithmetic, logic and shifts
    alu_st(FN_ADD, 5'd6,  5'd1, 5'd2, 3);
    alu_st(FN_SUB, 5'd7,  5'd1, 5'd2, 3);
    alu_st(FN_AND, 5'd8,  5'd3, 5'd2, 3);
    alu_st(FN_OR,  5'd9,  5'd3, 5'd2, 3);
    alu_st(FN_XOR, 5'd10, 5'd3, 5'd2, 3);
    alu_st(FN_SLL, 5'd11, 5'd3, 5'd4, 3);
    alu_st(FN_SRL, 5'd12, 5'd5, 5'd4, 3);
    alu_st(FN_SRA, 5'd13, 5'd5, 5'd4, 3);
    alu_st(FN_SUB, 5'd31, 5'd2, 5'd1, 3);
    // R4 signed compares
    alu_st(FN_SEQ, 5'd14, 5'd1, 5'd1, 4);
    alu_st(FN_SEQ, 5'd14, 5'd1, 5'd2, 4);
    alu_st(FN_SNE, 5'd15, 5'd1, 5'd2, 4);
    alu_st(FN_SNE, 5'd15, 5'd2, 5'd2, 4);
    alu_st(FN_SLT, 5'd16, 5'd2, 5'd1, 4);
    alu_st(FN_SLT, 5'd16, 5'd1, 5'd2, 4);
    alu_st(FN_SLT, 5'd17, 5'd5, 5'd1, 4);
    alu_st(FN_SGE, 5'd18, 5'd1, 5'd2, 4);
    alu_st(FN_SGE, 5'd18, 5'd2, 5'd1, 4);
    alu_st(FN_SGE, 5'd18, 5'd1, 5'd1, 4);
    // R5 register zero ignores ALU writes and loads
    alu_st(FN_ADD, 5'd0, 5'd1, 5'd1, 5);
    do_lw(5'd0, 5'd0, 16'h0200, 5);
    st(5'd0, 5);
    alu_st(FN_ADD, 5'd19, 5'd0, 5'd1, 5);
    // R7 store then R6 read back, and a base-register load
    do_sw(5'd1, 5'd0, 16'h0380, 7);
    do_lw(5'd20, 5'd0, 16'h0380, 6);
    st(5'd20, 6);
    do_lw(5'd21, 5'd4, 16'h0204, 6);
    st(5'd21, 6);
    // R10 undefined opcode is a two-step no-op
    put(enc_i(6'h3F, 5'd0, 5'd1, 16'h0000), 2, 10);
    st(5'd1, 10);
    // R8 branches: taken, not taken, both senses
    do_br(1'b0, 5'd0, 1, 8);
    st(5'd1, 8);
    do_br(1'b1, 5'd0, 1, 8);
    st(5'd2, 8);
    do_br(1'b1, 5'd1, 2, 8);
    st(5'd3, 8);
    do_br(1'b0, 5'd1, 1, 8);
    st(5'd4, 8);
    do_alu(FN_SEQ, 5'd22, 5'd1, 5'd2, 8);
    do_br(1'b0, 5'd22, 3, 8);
    st(5'd5, 8);
    // R8 backward branch onto itself
    halt_pc = pcb;
    put(enc_i(OP_BRZ, 5'd0, 5'd0, 16'hFFFC), 4, 8);
    fq.push_back({halt_pc, 4'd4, 4'd8});

    // R1 quiet port while in reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!mem_rd && !mem_wr && !mem_ifetch, 1,
          {29'd0, mem_rd, mem_wr, mem_ifetch}, 32'd0, "port idle in reset");
    end
    rst_n = 1'b1;

    while ((fq.size() != 0 || sq.size() != 0) && cyc < LIMIT) @(posedge clk);
    if (cyc >= LIMIT) chk(1'b0, 2, 32'(fq.size()), 32'd0, "watchdog expired");
    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule